// File: doc/BRIEF.md
# Accelerometer Digital Self-Test Sequencer

This block runs the digital side of a sensor self-test from a stream of ADC samples. Each self-test cycle is a fixed schedule counted in valid samples. First it lets the sensor settle and averages a zero reading with the stimulus off. Then it raises the self-test drive, settles again and averages a deflected reading. Last it drops the drive, settles and averages a second zero reading. When a cycle ends, the block makes two checks. The deflection must fall inside an open window set by two limit inputs. The two zero readings must agree to within a small tolerance.

Cycles repeat until enough of them pass or too many of them fail. At that point the block pulses a done flag and reports the verdict on a pass flag. The pass flag holds until the next start pulse. A start pulse aborts any run in progress and begins a fresh one. The settle length, the averaging depth, the tolerance and the pass and fail counts are all parameters.

Top module: `selftest_seq`

## Requirements
- R1: While reset is held and after it is released, `st_drive`, `st_pass` and `st_done` are all 0.
- R2: After a start pulse, the first 32 valid samples are discarded as settling. The next 64 valid samples are averaged into the first zero reading. `st_drive` stays 0 throughout.
- R3: `st_drive` goes to 1 after the 96th valid sample of the first zero phase. It stays 1 for exactly 96 further valid samples: 32 settling and 64 averaged into the deflected reading. It then returns to 0 for another 96 valid samples: 32 settling and 64 averaged into the second zero reading.
- R4: Each reading is the two's-complement sum of its 64 samples, shifted arithmetically right by 6. This rounds toward minus infinity, so the samples -4 and -3 in equal numbers average to -4.
- R5: A cycle fails its window check unless (deflected − first zero) is strictly greater than `lim_min` and strictly less than `lim_max`. All three values are signed. A deflection equal to either limit fails.
- R6: A cycle fails its repeatability check if |second zero − first zero| exceeds 4 LSB. A difference of exactly 4 passes.
- R7: A cycle that passes both checks increments a pass count. When the pass count reaches 2, the run ends with `st_pass` = 1.
- R8: A cycle that fails either check increments a fail count. The fail count is not cleared by passing cycles in between. When it reaches 3, the run ends with `st_pass` = 0.
- R9: `st_done` is a single-cycle pulse issued when the run ends. `st_pass` then keeps its value until the next start pulse.
- R10: A start pulse in any state restarts the schedule from its first settling sample. It drops `st_drive` and clears `st_pass` and both counts by the following cycle.
- R11: Cycles with `smp_vld` = 0 do not advance the schedule and do not enter any average, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin (or restart) a self-test run |
| smp_vld | input | 1 | `smp_data` carries a new sample this cycle |
| smp_data | input | 10 | Signed ADC sample |
| lim_min | input | 10 | Signed lower deflection limit (exclusive) |
| lim_max | input | 10 | Signed upper deflection limit (exclusive) |
| st_drive | output | 1 | Self-test stimulus enable |
| st_pass | output | 1 | Verdict of the last completed run (1 = pass) |
| st_done | output | 1 | One-cycle pulse when a run completes |

## Verification
The properties assume that `start` is a pulse and not a level held across a run, and that `smp_vld` is the only way a sample enters the schedule. Under those assumptions the drive can only rise on a valid sample, and the pass flag can only move on a done pulse or a start. The stimulus raises `start` for exactly one cycle per run and feeds samples only through `smp_vld`. It mixes in invalid cycles that carry extreme data, which the design must ignore. The limit inputs are held constant for the whole of each run, because the checks read them only at the end of a cycle.

// File: rtl/selftest_seq_pkg.sv
// Shared types for the self-test sequencer.
package selftest_seq_pkg;

    // Schedule position within one self-test cycle.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_Z1_SET = 3'd1,
        PH_Z1_AVG = 3'd2,
        PH_ON_SET = 3'd3,
        PH_ON_AVG = 3'd4,
        PH_Z2_SET = 3'd5,
        PH_Z2_AVG = 3'd6,
        PH_EVAL   = 3'd7
    } st_phase_e;

endpackage

// File: rtl/selftest_avg_acc.sv
// Sample accumulator: sums signed samples while add is high and clears on clr.
// Assumes the caller reads mean only on the cycle of the final sample.
// mean is (acc + sample) >>> AVG_LOG2, which includes the current sample.
module selftest_avg_acc #(
    parameter int W        = 10,
    parameter int AVG_LOG2 = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                add,
    input  logic signed [W-1:0] sample,
    output logic signed [W-1:0] mean
);
    localparam int AW = W + AVG_LOG2;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] sum_next;

    // Running sum including the present sample.
    always_comb begin
        sum_next = acc + {{AVG_LOG2{sample[W-1]}}, sample};
    end

    // Slicing off the low bits is an arithmetic shift (floor).
    assign mean = sum_next[AW-1:AVG_LOG2];

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (add) begin
            acc <= sum_next;
        end
    end
endmodule

// File: rtl/selftest_phase_ctrl.sv
// Schedule controller: steps through settle and average phases counted in valid samples.
// Issues capture strobes for the three readings and a one-cycle evaluate state.
// Assumes again is valid in the evaluate state.
module selftest_phase_ctrl
    import selftest_seq_pkg::*;
#(
    parameter int SETTLE_N = 32,
    parameter int AVG_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic smp_vld,
    input  logic again,
    output logic acc_clr,
    output logic acc_add,
    output logic cap_z1,
    output logic cap_on,
    output logic cap_z2,
    output logic eval,
    output logic drive
);
    localparam int AVG_N = 1 << AVG_LOG2;
    localparam int SPAN  = (SETTLE_N > AVG_N) ? SETTLE_N : AVG_N;
    localparam int CW    = (SPAN > 1) ? $clog2(SPAN) : 1;

    st_phase_e     phase;
    logic [CW-1:0] cnt;
    logic          in_set;
    logic          in_avg;
    logic          set_end;
    logic          avg_end;

    // Phase class decode.
    always_comb begin
        in_set  = (phase == PH_Z1_SET) || (phase == PH_ON_SET) || (phase == PH_Z2_SET);
        in_avg  = (phase == PH_Z1_AVG) || (phase == PH_ON_AVG) || (phase == PH_Z2_AVG);
        set_end = in_set && smp_vld && (cnt == CW'(SETTLE_N - 1));
        avg_end = in_avg && smp_vld && (cnt == CW'(AVG_N - 1));
    end

    // Phase and sample counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= PH_Z1_SET;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: cnt <= '0;
                PH_EVAL: begin
                    cnt   <= '0;
                    phase <= again ? PH_Z1_SET : PH_IDLE;
                end
                default: begin
                    if (set_end || avg_end) begin
                        cnt   <= '0;
                        phase <= st_phase_e'(phase + 3'd1);
                    end else if (smp_vld) begin
                        cnt <= cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    // Datapath strobes.
    always_comb begin
        acc_clr = !in_avg;
        acc_add = in_avg && smp_vld;
        cap_z1  = avg_end && (phase == PH_Z1_AVG);
        cap_on  = avg_end && (phase == PH_ON_AVG);
        cap_z2  = avg_end && (phase == PH_Z2_AVG);
        eval    = (phase == PH_EVAL);
        drive   = (phase == PH_ON_SET) || (phase == PH_ON_AVG);
    end
endmodule

// File: rtl/selftest_judge.sv
// Cycle judge: windowed deflection test and zero repeatability test, combinational.
// Assumes the readings and limits are stable while eval is sampled.
module selftest_judge #(
    parameter int W        = 10,
    parameter int ZERO_TOL = 4
) (
    input  logic signed [W-1:0] zero_a,
    input  logic signed [W-1:0] defl_rd,
    input  logic signed [W-1:0] zero_b,
    input  logic signed [W-1:0] lo_lim,
    input  logic signed [W-1:0] hi_lim,
    output logic                cycle_ok
);
    logic signed [W:0] defl;
    logic signed [W:0] zdiff;
    logic signed [W:0] zmag;
    logic signed [W:0] lo_x;
    logic signed [W:0] hi_x;
    logic              win_ok;
    logic              zero_ok;

    // One extra bit keeps the differences free of overflow.
    always_comb begin
        defl    = {defl_rd[W-1], defl_rd} - {zero_a[W-1], zero_a};
        zdiff   = {zero_b[W-1], zero_b} - {zero_a[W-1], zero_a};
        zmag    = zdiff[W] ? -zdiff : zdiff;
        lo_x    = {lo_lim[W-1], lo_lim};
        hi_x    = {hi_lim[W-1], hi_lim};
        win_ok  = (defl > lo_x) && (defl < hi_x);
        zero_ok = (zmag <= (W+1)'(ZERO_TOL));
        cycle_ok = win_ok && zero_ok;
    end
endmodule

// File: rtl/selftest_tally.sv
// Pass/fail tally: counts judged cycles and declares the verdict.
// The pass and fail counts are independent; start clears both and the verdict.
module selftest_tally #(
    parameter int PASS_NEED  = 2,
    parameter int FAIL_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic eval,
    input  logic cycle_ok,
    output logic again,
    output logic done,
    output logic pass
);
    localparam int PCW = $clog2(PASS_NEED + 1);
    localparam int FCW = $clog2(FAIL_LIMIT + 1);

    logic [PCW-1:0] pass_cnt;
    logic [FCW-1:0] fail_cnt;
    logic           hit_pass;
    logic           hit_fail;

    // Decision reached in this evaluate cycle.
    always_comb begin
        hit_pass = eval && cycle_ok && (pass_cnt == PCW'(PASS_NEED - 1));
        hit_fail = eval && !cycle_ok && (fail_cnt == FCW'(FAIL_LIMIT - 1));
        again    = !(hit_pass || hit_fail);
    end

    // Counters, done pulse and held verdict.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pass_cnt <= '0;
            fail_cnt <= '0;
            done     <= 1'b0;
            pass     <= 1'b0;
        end else begin
            done <= hit_pass || hit_fail;
            if (hit_pass || hit_fail) begin
                pass_cnt <= '0;
                fail_cnt <= '0;
                pass     <= hit_pass;
            end else if (eval && cycle_ok) begin
                pass_cnt <= pass_cnt + PCW'(1);
            end else if (eval) begin
                fail_cnt <= fail_cnt + FCW'(1);
            end
        end
    end
endmodule

// File: rtl/selftest_seq.sv
// Self-test sequencer top: schedule control, averaging, reading storage, judgement and tally.
// Assumes start is a single-cycle pulse and the limits hold steady during a run.
module selftest_seq #(
    parameter int W          = 10,
    parameter int SETTLE_N   = 32,
    parameter int AVG_LOG2   = 6,
    parameter int ZERO_TOL   = 4,
    parameter int PASS_NEED  = 2,
    parameter int FAIL_LIMIT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                smp_vld,
    input  logic signed [W-1:0] smp_data,
    input  logic signed [W-1:0] lim_min,
    input  logic signed [W-1:0] lim_max,
    output logic                st_drive,
    output logic                st_pass,
    output logic                st_done
);
    logic                acc_clr;
    logic                acc_add;
    logic                cap_z1;
    logic                cap_on;
    logic                cap_z2;
    logic                eval;
    logic                again;
    logic                cycle_ok;
    logic signed [W-1:0] mean;
    logic signed [W-1:0] z1_q;
    logic signed [W-1:0] on_q;
    logic signed [W-1:0] z2_q;

    selftest_phase_ctrl #(
        .SETTLE_N (SETTLE_N),
        .AVG_LOG2 (AVG_LOG2)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .smp_vld (smp_vld),
        .again   (again),
        .acc_clr (acc_clr),
        .acc_add (acc_add),
        .cap_z1  (cap_z1),
        .cap_on  (cap_on),
        .cap_z2  (cap_z2),
        .eval    (eval),
        .drive   (st_drive)
    );

    selftest_avg_acc #(
        .W        (W),
        .AVG_LOG2 (AVG_LOG2)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .add    (acc_add),
        .sample (smp_data),
        .mean   (mean)
    );

    // Reading registers loaded at the end of each averaging phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z1_q <= '0;
            on_q <= '0;
            z2_q <= '0;
        end else begin
            if (cap_z1) z1_q <= mean;
            if (cap_on) on_q <= mean;
            if (cap_z2) z2_q <= mean;
        end
    end

    selftest_judge #(
        .W        (W),
        .ZERO_TOL (ZERO_TOL)
    ) u_judge (
        .zero_a   (z1_q),
        .defl_rd  (on_q),
        .zero_b   (z2_q),
        .lo_lim   (lim_min),
        .hi_lim   (lim_max),
        .cycle_ok (cycle_ok)
    );

    selftest_tally #(
        .PASS_NEED  (PASS_NEED),
        .FAIL_LIMIT (FAIL_LIMIT)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .eval     (eval),
        .cycle_ok (cycle_ok),
        .again    (again),
        .done     (st_done),
        .pass     (st_pass)
    );
endmodule

// File: rtl/selftest_seq_chk.sv
// Property checker for the self-test sequencer, attached to the top through bind.
module selftest_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic smp_vld,
    input logic st_drive,
    input logic st_pass,
    input logic st_done
);
    // R9: done never lasts two cycles.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |=> !st_done);

    // R9: the verdict moves only with a done pulse or a start.
    a_r9_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (st_done || $stable(st_pass)));

    // R10: start clears the verdict, the drive and done.
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!st_pass && !st_drive && !st_done));

    // R3, R11: the drive rises only on a valid sample.
    a_r3_drive_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_drive) |-> $past(smp_vld));

    // R3: the stimulus is off when a verdict is issued.
    a_r3_drive_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> !st_drive);
endmodule

bind selftest_seq selftest_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .smp_vld  (smp_vld),
    .st_drive (st_drive),
    .st_pass  (st_pass),
    .st_done  (st_done)
);

// File: tb/selftest_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: attempt tasks push expected verdicts, a monitor pops them on done.
module selftest_seq_test;
    localparam int W = 10;
    localparam int PASS_NEED = 2;
    localparam int FAIL_LIMIT = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                smp_vld = 1'b0;
    logic signed [W-1:0] smp_data = '0;
    logic signed [W-1:0] lim_min = '0;
    logic signed [W-1:0] lim_max = '0;
    logic                st_drive;
    logic                st_pass;
    logic                st_done;

    int vectors = 0;
    int miscomp = 0;
    int pc = 0;
    int fc = 0;
    int cyc = 0;
    bit exp_q[$];
    bit prev_done = 1'b0;

    always #4 clk = ~clk;

    selftest_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .lim_min  (lim_min),
        .lim_max  (lim_max),
        .st_drive (st_drive),
        .st_pass  (st_pass),
        .st_done  (st_done)
    );

    task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!cond) begin
            miscomp++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit model_ok(input int a, input int b, input int c);
        int d;
        int z;
        d = b - a;
        z = (c > a) ? c - a : a - c;
        return (d > int'(lim_min)) && (d < int'(lim_max)) && (z <= 4);
    endfunction

    // R10: start pulse, then the verdict and the drive must read 0.
    task automatic start_pulse();
        @(negedge clk);
        smp_vld = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(st_pass == 1'b0, "R10", "pass after start", st_pass, 0);
        chk(st_drive == 1'b0, "R10", "drive after start", st_drive, 0);
        pc = 0;
        fc = 0;
    endtask

    // One self-test cycle: three 96-sample segments with bases a, b, c.
    // alt adds +1 on odd samples (R4 floor); junk inserts invalid cycles (R11).
    task automatic attempt(input int a, input int b, input int c, input bit alt, input bit junk);
        for (int seg = 0; seg < 3; seg++) begin
            int base;
            base = (seg == 0) ? a : (seg == 1) ? b : c;
            for (int i = 0; i < 96; i++) begin
                if (junk && (i % 5 == 2)) begin
                    @(negedge clk);
                    smp_vld = 1'b0;
                    smp_data = (i % 2 == 1) ? 10'sh1FF : 10'sh200;
                end
                @(negedge clk);
                chk(st_drive == (seg == 1), (seg == 1) ? "R3" : "R2", "drive level", st_drive, (seg == 1));
                smp_vld = 1'b1;
                smp_data = W'(base + (alt ? (i % 2) : 0));
            end
        end
        @(negedge clk);
        smp_vld = 1'b0;
        if (model_ok(a, b, c)) pc++;
        else fc++;
        if (pc == PASS_NEED) begin
            exp_q.push_back(1'b1);
            pc = 0;
            fc = 0;
        end else if (fc == FAIL_LIMIT) begin
            exp_q.push_back(1'b0);
            pc = 0;
            fc = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    // R9: verdict held while idle.
    task automatic hold_check(input bit e);
        repeat (5) begin
            @(negedge clk);
            chk(st_pass == e, "R9", "verdict hold", st_pass, e);
        end
        chk(exp_q.size() == 0, "R9", "pending verdicts", exp_q.size(), 0);
    endtask

    // Monitor: pops expected verdicts on done and checks the pulse width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (st_done) begin
                chk(!prev_done, "R9", "done width", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(st_pass == e, e ? "R7" : "R8", "verdict", st_pass, e);
                end
            end
            prev_done <= st_done;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscomp++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(st_drive == 0 && st_pass == 0 && st_done == 0, "R1", "outputs in reset",
            {st_drive, st_pass, st_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(st_drive == 0 && st_pass == 0 && st_done == 0, "R1", "outputs after reset",
            {st_drive, st_pass, st_done}, 0);

        // R7: two clean cycles pass.
        lim_min = 10'sd20;
        lim_max = 10'sd200;
        start_pulse();
        attempt(10, 110, 12, 1'b0, 1'b0);
        attempt(10, 110, 12, 1'b0, 1'b0);
        hold_check(1'b1);

        // R5, R8: deflection equal to lim_min fails three times.
        start_pulse();
        attempt(10, 30, 10, 1'b0, 1'b0);
        attempt(10, 30, 10, 1'b0, 1'b0);
        attempt(10, 30, 10, 1'b0, 1'b0);
        hold_check(1'b0);

        // R5: deflection equal to lim_max fails, one below passes.
        lim_min = 10'sd20;
        lim_max = 10'sd100;
        start_pulse();
        attempt(0, 100, 0, 1'b0, 1'b0);
        attempt(0, 99, 0, 1'b0, 1'b0);
        attempt(0, 21, 0, 1'b0, 1'b0);
        hold_check(1'b1);

        // R6, R8: zero difference 5 fails, 4 passes; non-consecutive fails.
        lim_min = 10'sd20;
        lim_max = 10'sd200;
        start_pulse();
        attempt(10, 110, 15, 1'b0, 1'b0);
        attempt(10, 110, 5, 1'b0, 1'b0);
        attempt(10, 110, 14, 1'b0, 1'b0);
        attempt(10, 110, 16, 1'b0, 1'b0);
        hold_check(1'b0);

        // R4, R11: negative alternating samples floor to -4 (deflection 100 > 99), junk cycles ignored.
        lim_min = 10'sd99;
        lim_max = 10'sd200;
        start_pulse();
        attempt(-4, 96, -4, 1'b1, 1'b1);
        attempt(-4, 96, -4, 1'b1, 1'b1);
        hold_check(1'b1);

        // R10: restart in the middle of the deflected phase.
        lim_min = 10'sd20;
        lim_max = 10'sd200;
        start_pulse();
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            smp_vld = 1'b1;
            smp_data = (i < 96) ? 10'sd5 : 10'sd80;
        end
        @(negedge clk);
        smp_vld = 1'b0;
        chk(st_drive == 1'b1, "R3", "drive mid run", st_drive, 1);
        start_pulse();
        attempt(5, 80, 6, 1'b0, 1'b0);
        attempt(5, 80, 6, 1'b0, 1'b0);
        hold_check(1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule